// File: doc/BRIEF.md
# ATM Cell Receive Framer with HEC

This block takes ATM cells one byte per clock from a PHY-side byte interface, finds the cell boundaries from a start-of-cell flag and polices each cell's length. A cell has 53 bytes: 5 header bytes followed by 48 payload bytes. The fifth header byte carries the HEC, which is a CRC-8 over the first four header bytes. The receive side checks the HEC and drops any cell that fails. It drops a cell that a fresh start-of-cell cuts short. It clips any bytes that arrive after the 53rd. Each kind of loss has its own saturating counter.

Cells that pass are written into a receive buffer that holds eight cells. A cell becomes visible only after its last byte has arrived. The buffer is drained one byte at a time through a valid/ready port, with first and last markers. While all eight slots are taken, the ready signal towards the PHY is low.

A separate transmit lane passes a byte stream through with one cycle of delay. It replaces the fifth byte of every cell with the HEC computed over the four bytes before it.

Top module: `atm_cell_framer`

## Requirements
- R1: A byte is accepted when `rx_valid` and `rx_ready` are both high. An accepted byte with `rx_soc`=1 opens a cell as its byte 1, and later accepted bytes with `rx_soc`=0 fill bytes 2, 3 and so on. Accepted bytes with `rx_soc`=0 when no cell has been opened since reset are ignored.
- R2: The HEC is the CRC-8 with generator x^8+x^2+x+1, initial value 0, most significant bit first, taken over bytes 1 to 4 and then XORed with 0x55. An all-zero header therefore has HEC 0x55. A cell whose byte 5 matches this value and which reaches 53 bytes is delivered unchanged, all 53 bytes, on `cell_data`.
- R3: A cell that reaches 53 bytes but whose byte 5 does not match the HEC is dropped whole, and `hec_err_count` increments by one.
- R4: When a start-of-cell byte is accepted while the open cell holds fewer than 53 bytes, the open cell is dropped and `short_count` increments by one.
- R5: Accepted bytes that follow the 53rd byte of a cell, up to the next start-of-cell, are discarded. `long_count` increments once for each such cell, and the cell is kept with its first 53 bytes.
- R6: A cell is stored only once its 53rd byte is accepted, and it is offered from the next cycle on. Stored cells leave in arrival order, one byte per cycle in which `cell_valid` and `cell_ready` are both high. `cell_first` marks byte 1 and `cell_last` marks byte 53. Data and markers hold while the byte is stalled.
- R7: `rx_ready` is low exactly when 8 cells are stored. A slot is freed in the cycle after its 53rd byte is read. Bytes offered while `rx_ready` is low are not taken.
- R8: All three counters saturate at 2^CNT_W-1, which is 255 by default.
- R9: `tx_valid_out`, `tx_soc_out` and `tx_data_out` follow the transmit inputs one cycle later. The 4th valid byte after a valid start-of-cell byte (cell byte 5) is replaced by the HEC of cell bytes 1 to 4, computed as in R2. All other bytes pass unchanged, and a new start-of-cell restarts the header count.
- R10: After reset, `rx_ready` is 1, `cell_valid` and `tx_valid_out` are 0, and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Received byte from the PHY |
| rx_valid | input | 1 | Received byte present |
| rx_soc | input | 1 | Received byte is byte 1 of a cell |
| rx_ready | output | 1 | Framer can take a byte (buffer not full) |
| cell_data | output | 8 | Stored cell byte |
| cell_valid | output | 1 | Stored byte available |
| cell_ready | input | 1 | Consumer takes the stored byte |
| cell_first | output | 1 | Stored byte is byte 1 of its cell |
| cell_last | output | 1 | Stored byte is byte 53 of its cell |
| hec_err_count | output | CNT_W | Cells dropped for HEC mismatch |
| short_count | output | CNT_W | Cells dropped for being cut short |
| long_count | output | CNT_W | Cells clipped for excess bytes |
| tx_data_in | input | 8 | Transmit byte in |
| tx_valid_in | input | 1 | Transmit byte present |
| tx_soc_in | input | 1 | Transmit byte is byte 1 of a cell |
| tx_data_out | output | 8 | Transmit byte out, HEC inserted |
| tx_valid_out | output | 1 | Transmit byte out present |
| tx_soc_out | output | 1 | Transmit byte out is byte 1 of a cell |

## Verification
The receive side is driven with an all-zero header, whose HEC is known to be 0x55, and with headers that use every bit. These runs separate a correct CRC from one with a wrong generator, a wrong seed or a wrong coset. A cell with a single flipped HEC bit, a 20-byte cell cut off by a new start-of-cell and a 60-byte cell each touch exactly one of the three counters, so a loss booked on the wrong counter, or a wrong cell kept, shows up at once. The buffer is filled to eight cells with the consumer stalled, start-of-cell bytes are offered while ready is low, and the buffer is then drained under an irregular ready pattern. This exposes off-by-one errors in the occupancy count and in the freeing of slots. A run of over 255 one-byte cells drives a counter into saturation. Transmit cells with gaps and with an aborted header check the byte position chosen for HEC insertion.

// File: rtl/atm_framer_pkg.sv
package atm_framer_pkg;

   // one byte of a CRC-8, generator x^8+x^2+x+1, msb first
   function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] b);
      logic [7:0] c;
      c = crc ^ b;
      for (int i = 0; i < 8; i++) begin
         c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
      end
      return c;
   endfunction

   typedef enum logic [1:0] {
      EV_HEC   = 2'd0,
      EV_SHORT = 2'd1,
      EV_LONG  = 2'd2
   } loss_ev_e;

   localparam int NUM_EV = 3;

endpackage

// File: rtl/atm_sat_counter.sv
module atm_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  count <= '0;
      else if (inc && count != '1) count <= count + W'(1);
   end
endmodule

// File: rtl/atm_rx_delineate.sv
module atm_rx_delineate
   import atm_framer_pkg::*;
#(
   parameter int          CELL_BYTES = 53,
   parameter int          HDR_BYTES  = 5,
   parameter logic [7:0]  HEC_COSET  = 8'h55,
   localparam int         IDX_W      = $clog2(CELL_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer,
   input  logic             soc,
   input  logic [7:0]       din,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic             commit,
   output logic             ev_short,
   output logic             ev_long,
   output logic             ev_hec
);
   localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(CELL_BYTES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
   localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(HDR_BYTES - 1);

   logic             in_cell;
   logic [IDX_W-1:0] idx;
   logic [7:0]       crc;
   logic             hec_bad;
   logic             clipped;
   logic             start, cont, room;

   assign start    = xfer & soc;
   assign cont     = xfer & ~soc & in_cell;
   assign room     = idx < FULL_IDX;
   assign wr_en    = start | (cont & room);
   assign wr_idx   = start ? '0 : idx;
   assign ev_short = start & in_cell & room;
   assign commit   = cont & (idx == LAST_IDX) & ~hec_bad;
   assign ev_hec   = cont & (idx == LAST_IDX) &  hec_bad;
   assign ev_long  = cont & ~room & ~clipped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_cell <= 1'b0;
         idx     <= '0;
         crc     <= '0;
         hec_bad <= 1'b0;
         clipped <= 1'b0;
      end else if (start) begin
         in_cell <= 1'b1;
         idx     <= IDX_W'(1);
         crc     <= hec_step(8'h00, din);
         hec_bad <= 1'b0;
         clipped <= 1'b0;
      end else if (cont) begin
         if (room) begin
            idx <= idx + IDX_W'(1);
            if (idx < HEC_IDX)  crc     <= hec_step(crc, din);
            if (idx == HEC_IDX) hec_bad <= (din != (crc ^ HEC_COSET));
         end else begin
            clipped <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/atm_cell_buffer.sv
module atm_cell_buffer #(
   parameter int  CELL_BYTES = 53,
   parameter int  DEPTH      = 8,
   localparam int IDX_W      = $clog2(CELL_BYTES + 1),
   localparam int PTR_W      = $clog2(DEPTH),
   localparam int OCC_W      = $clog2(DEPTH + 1),
   localparam int AW         = $clog2(DEPTH * CELL_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic             commit,
   input  logic             rd_ready,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             rd_first,
   output logic             rd_last,
   output logic             full
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
   localparam logic [OCC_W-1:0] OCC_MAX  = OCC_W'(DEPTH);
   localparam logic [AW-1:0]    CB_A     = AW'(CELL_BYTES);

   logic [7:0]       mem [DEPTH*CELL_BYTES];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [IDX_W-1:0] rd_idx;
   logic [OCC_W-1:0] occ;
   logic [AW-1:0]    wa, ra;
   logic             pop, pop_cell;

   // pointer wrap: free running for power-of-two depth, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   assign wa       = AW'(wr_ptr) * CB_A + AW'(wr_idx);
   assign ra       = AW'(rd_ptr) * CB_A + AW'(rd_idx);
   assign rd_valid = occ != '0;
   assign rd_data  = mem[ra];
   assign rd_first = rd_idx == '0;
   assign rd_last  = rd_idx == LAST_IDX;
   assign full     = occ == OCC_MAX;
   assign pop      = rd_valid & rd_ready;
   assign pop_cell = pop & rd_last;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wa] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         rd_idx <= '0;
         occ    <= '0;
      end else begin
         if (commit) wr_ptr <= wr_nxt;
         if (pop) begin
            if (rd_last) begin
               rd_idx <= '0;
               rd_ptr <= rd_nxt;
            end else begin
               rd_idx <= rd_idx + IDX_W'(1);
            end
         end
         case ({commit, pop_cell})
            2'b10:   occ <= occ + OCC_W'(1);
            2'b01:   occ <= occ - OCC_W'(1);
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/atm_tx_hec_insert.sv
module atm_tx_hec_insert
   import atm_framer_pkg::*;
#(
   parameter int         HDR_BYTES = 5,
   parameter logic [7:0] HEC_COSET = 8'h55,
   localparam int        TW        = $clog2(HDR_BYTES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data,
   input  logic       in_valid,
   input  logic       in_soc,
   output logic [7:0] out_data,
   output logic       out_valid,
   output logic       out_soc
);
   localparam logic [TW-1:0] HEC_POS = TW'(HDR_BYTES - 1);

   logic [TW-1:0] tpos;
   logic [7:0]    crc;
   logic          hec_slot;

   assign hec_slot = in_valid & ~in_soc & (tpos == HEC_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpos      <= '0;
         crc       <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
         out_soc   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_soc   <= in_valid & in_soc;
         out_data  <= hec_slot ? (crc ^ HEC_COSET) : in_data;
         if (in_valid) begin
            if (in_soc) begin
               tpos <= TW'(1);
               crc  <= hec_step(8'h00, in_data);
            end else if (tpos != '0) begin
               tpos <= (tpos == HEC_POS) ? '0 : tpos + TW'(1);
               crc  <= hec_step(crc, in_data);
            end
         end
      end
   end
endmodule

// File: rtl/atm_cell_framer.sv
module atm_cell_framer
   import atm_framer_pkg::*;
#(
   parameter int         CELL_BYTES = 53,
   parameter int         HDR_BYTES  = 5,
   parameter int         DEPTH      = 8,
   parameter int         CNT_W      = 8,
   parameter logic [7:0] HEC_COSET  = 8'h55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       rx_data,
   input  logic             rx_valid,
   input  logic             rx_soc,
   output logic             rx_ready,
   output logic [7:0]       cell_data,
   output logic             cell_valid,
   input  logic             cell_ready,
   output logic             cell_first,
   output logic             cell_last,
   output logic [CNT_W-1:0] hec_err_count,
   output logic [CNT_W-1:0] short_count,
   output logic [CNT_W-1:0] long_count,
   input  logic [7:0]       tx_data_in,
   input  logic             tx_valid_in,
   input  logic             tx_soc_in,
   output logic [7:0]       tx_data_out,
   output logic             tx_valid_out,
   output logic             tx_soc_out
);
   localparam int IDX_W = $clog2(CELL_BYTES + 1);

   if (HDR_BYTES < 2) begin : g_bad_hdr
      $error("HDR_BYTES must be at least 2");
   end
   if (CELL_BYTES <= HDR_BYTES) begin : g_bad_cell
      $error("CELL_BYTES must exceed HDR_BYTES");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic             xfer, full;
   logic             wr_en, commit;
   logic [IDX_W-1:0] wr_idx;
   logic [NUM_EV-1:0] ev;
   logic [CNT_W-1:0] cnts [NUM_EV];

   assign rx_ready = ~full;
   assign xfer     = rx_valid & rx_ready;

   atm_rx_delineate #(
      .CELL_BYTES (CELL_BYTES),
      .HDR_BYTES  (HDR_BYTES),
      .HEC_COSET  (HEC_COSET)
   ) u_delin (
      .clk      (clk),
      .rst_n    (rst_n),
      .xfer     (xfer),
      .soc      (rx_soc),
      .din      (rx_data),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .commit   (commit),
      .ev_short (ev[EV_SHORT]),
      .ev_long  (ev[EV_LONG]),
      .ev_hec   (ev[EV_HEC])
   );

   atm_cell_buffer #(
      .CELL_BYTES (CELL_BYTES),
      .DEPTH      (DEPTH)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (rx_data),
      .commit   (commit),
      .rd_ready (cell_ready),
      .rd_valid (cell_valid),
      .rd_data  (cell_data),
      .rd_first (cell_first),
      .rd_last  (cell_last),
      .full     (full)
   );

   for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
      atm_sat_counter #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (ev[g]),
         .count (cnts[g])
      );
   end

   assign hec_err_count = cnts[EV_HEC];
   assign short_count   = cnts[EV_SHORT];
   assign long_count    = cnts[EV_LONG];

   atm_tx_hec_insert #(
      .HDR_BYTES (HDR_BYTES),
      .HEC_COSET (HEC_COSET)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (tx_data_in),
      .in_valid  (tx_valid_in),
      .in_soc    (tx_soc_in),
      .out_data  (tx_data_out),
      .out_valid (tx_valid_out),
      .out_soc   (tx_soc_out)
   );
endmodule

// File: rtl/atm_cell_framer_chk.sv
module atm_cell_framer_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_ready,
   input logic             cell_valid,
   input logic             cell_ready,
   input logic             cell_first,
   input logic             cell_last,
   input logic [7:0]       cell_data,
   input logic [CNT_W-1:0] hec_err_count,
   input logic [CNT_W-1:0] short_count,
   input logic [CNT_W-1:0] long_count,
   input logic             tx_valid_in,
   input logic             tx_valid_out
);
   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_valid && !cell_ready |=> cell_valid && $stable(cell_data));

   // R6
   first_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_valid && cell_ready && cell_last |=> !cell_valid || cell_first);

   // R7
   full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready && !(cell_valid && cell_ready) |=> !rx_ready);

   // R3
   hec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hec_err_count) |-> hec_err_count == CNT_W'($past(hec_err_count) + 1'b1));

   // R4
   short_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(short_count) |-> short_count == CNT_W'($past(short_count) + 1'b1));

   // R5
   long_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(long_count) |-> long_count == CNT_W'($past(long_count) + 1'b1));

   // R8
   short_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_count == '1 |=> short_count == '1);

   // R9
   tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_in |=> tx_valid_out);

   // R9
   tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid_in |=> !tx_valid_out);
endmodule

bind atm_cell_framer atm_cell_framer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rx_ready      (rx_ready),
   .cell_valid    (cell_valid),
   .cell_ready    (cell_ready),
   .cell_first    (cell_first),
   .cell_last     (cell_last),
   .cell_data     (cell_data),
   .hec_err_count (hec_err_count),
   .short_count   (short_count),
   .long_count    (long_count),
   .tx_valid_in   (tx_valid_in),
   .tx_valid_out  (tx_valid_out)
);

// File: tb/sim_atm_cell_framer.sv
`timescale 1ns/1ps
module sim_atm_cell_framer;
   localparam int CNT_W = 8;
   localparam int MAXC  = (1 << CNT_W) - 1;
   localparam int CB    = 53;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [7:0] d_rd = '0, d_td = '0;
   logic d_rv = 0, d_rs = 0, d_cr = 0, d_tv = 0, d_ts = 0;

   logic             rx_ready, cell_valid, cell_first, cell_last;
   logic [7:0]       cell_data, tx_data_out;
   logic [CNT_W-1:0] hec_err_count, short_count, long_count;
   logic             tx_valid_out, tx_soc_out;

   atm_cell_framer #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .rx_data(d_rd), .rx_valid(d_rv), .rx_soc(d_rs), .rx_ready(rx_ready),
      .cell_data(cell_data), .cell_valid(cell_valid), .cell_ready(d_cr),
      .cell_first(cell_first), .cell_last(cell_last),
      .hec_err_count(hec_err_count), .short_count(short_count), .long_count(long_count),
      .tx_data_in(d_td), .tx_valid_in(d_tv), .tx_soc_in(d_ts),
      .tx_data_out(tx_data_out), .tx_valid_out(tx_valid_out), .tx_soc_out(tx_soc_out)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   logic [7:0] fifo[$];
   logic [7:0] cur[$];
   int  rd_pos = 0;
   bit  in_cell = 0, clipped = 0, acc = 0;
   int  m_hec = 0, m_short = 0, m_long = 0;
   int  tpos = 0;
   logic [7:0] thdr [4];
   bit  e_tv = 0, e_ts = 0;
   logic [7:0] e_td = '0;

   // HEC by polynomial long division of header*x^8 by 0x107
   function automatic logic [7:0] ref_hec(input logic [7:0] a, b, c, d);
      logic [39:0] v;
      v = {a, b, c, d, 8'h00};
      for (int i = 39; i >= 8; i--) if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
      return v[7:0] ^ 8'h55;
   endfunction

   function automatic bit m_ready();
      return ((fifo.size() + rd_pos) / CB) < 8;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic model_step();
      bit rdy;
      rdy = m_ready();
      acc = d_rv && rdy;
      if (fifo.size() != 0 && d_cr) begin
         void'(fifo.pop_front());
         rd_pos = (rd_pos == CB - 1) ? 0 : rd_pos + 1;
      end
      if (acc) begin
         if (d_rs) begin
            if (in_cell && cur.size() < CB && m_short < MAXC) m_short++;
            cur.delete();
            cur.push_back(d_rd);
            in_cell = 1;
            clipped = 0;
         end else if (in_cell) begin
            if (cur.size() < CB) begin
               cur.push_back(d_rd);
               if (cur.size() == CB) begin
                  if (cur[4] !== ref_hec(cur[0], cur[1], cur[2], cur[3])) begin
                     if (m_hec < MAXC) m_hec++;
                  end else begin
                     foreach (cur[k]) fifo.push_back(cur[k]);
                  end
               end
            end else if (!clipped) begin
               if (m_long < MAXC) m_long++;
               clipped = 1;
            end
         end
      end
      e_tv = d_tv;
      e_ts = d_tv && d_ts;
      e_td = d_td;
      if (d_tv) begin
         if (d_ts) begin
            thdr[0] = d_td;
            tpos = 1;
         end else if (tpos > 0) begin
            if (tpos == 4) begin
               e_td = ref_hec(thdr[0], thdr[1], thdr[2], thdr[3]);
               tpos = 0;
            end else begin
               thdr[tpos] = d_td;
               tpos++;
            end
         end
      end
   endtask

   task automatic compare();
      chk("R7", "rx_ready", 32'(rx_ready), 32'(m_ready()));
      chk("R6", "cell_valid", 32'(cell_valid), 32'(fifo.size() != 0));
      if (fifo.size() != 0) begin
         chk("R2", "cell_data", 32'(cell_data), 32'(fifo[0]));
         chk("R6", "cell_first", 32'(cell_first), 32'(rd_pos == 0));
         chk("R6", "cell_last", 32'(cell_last), 32'(rd_pos == CB - 1));
      end
      chk("R3", "hec_err_count", 32'(hec_err_count), 32'(m_hec));
      chk("R4", "short_count", 32'(short_count), 32'(m_short));
      chk("R5", "long_count", 32'(long_count), 32'(m_long));
      chk("R9", "tx_valid_out", 32'(tx_valid_out), 32'(e_tv));
      if (e_tv) begin
         chk("R9", "tx_data_out", 32'(tx_data_out), 32'(e_td));
         chk("R9", "tx_soc_out", 32'(tx_soc_out), 32'(e_ts));
      end
   endtask

   task automatic cyc();
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic put(input logic [7:0] b, input bit s);
      d_rv = 1; d_rs = s; d_rd = b;
      acc = 0;
      while (!acc) cyc();
      d_rv = 0; d_rs = 0;
   endtask

   task automatic idle(input int n);
      d_rv = 0; d_tv = 0;
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic send_cell(input logic [7:0] h0, h1, h2, h3, input bit bad, input int n, input int seed);
      logic [7:0] hec;
      hec = ref_hec(h0, h1, h2, h3) ^ {7'd0, bad};
      for (int i = 0; i < n; i++) begin
         case (i)
            0: put(h0, 1);
            1: put(h1, 0);
            2: put(h2, 0);
            3: put(h3, 0);
            4: put(hec, 0);
            default: put(8'(i * 7 + seed), 0);
         endcase
      end
   endtask

   task automatic tx_cell(input logic [7:0] h0, h1, h2, h3, input int n, input bit gap);
      for (int i = 0; i < n; i++) begin
         d_tv = 1;
         d_ts = (i == 0);
         case (i)
            0: d_td = h0;
            1: d_td = h1;
            2: d_td = h2;
            3: d_td = h3;
            4: d_td = 8'hAA;
            default: d_td = 8'(i * 3);
         endcase
         cyc();
         if (gap && (i % 4 == 1)) begin
            d_tv = 0;
            cyc();
         end
      end
      d_tv = 0; d_ts = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      chk("R10", "rx_ready", 32'(rx_ready), 32'd1);
      chk("R10", "cell_valid", 32'(cell_valid), 32'd0);
      chk("R10", "tx_valid_out", 32'(tx_valid_out), 32'd0);
      chk("R10", "counters", 32'({hec_err_count, short_count, long_count}), 32'd0);

      // R1 stray bytes before any start-of-cell are ignored
      d_cr = 1;
      for (int i = 0; i < 60; i++) put(8'(i), 0);
      idle(2);
      chk("R1", "stray cell_valid", 32'(cell_valid), 32'd0);
      chk("R1", "stray counters", 32'({hec_err_count, short_count, long_count}), 32'd0);

      // R2 zero header (HEC 0x55), full-bit header
      send_cell(8'h00, 8'h00, 8'h00, 8'h00, 0, 53, 1);
      send_cell(8'hFF, 8'hA5, 8'h3C, 8'h81, 0, 53, 9);
      // R3 flipped HEC bit
      send_cell(8'h12, 8'h34, 8'h56, 8'h78, 1, 53, 4);
      // R4 short cell ended by the next start
      send_cell(8'h01, 8'h02, 8'h03, 8'h04, 0, 20, 5);
      send_cell(8'h0A, 8'h0B, 8'h0C, 8'h0D, 0, 53, 6);
      // R5 long cell then a good one
      send_cell(8'h40, 8'h41, 8'h42, 8'h43, 0, 60, 7);
      send_cell(8'h50, 8'h51, 8'h52, 8'h53, 0, 53, 8);
      idle(120);
      chk("R3", "hec_err_count after bad", 32'(hec_err_count), 32'd1);
      chk("R4", "short_count after short", 32'(short_count), 32'd1);
      chk("R5", "long_count after long", 32'(long_count), 32'd1);

      // R7 fill to eight cells with consumer stalled
      d_cr = 0;
      for (int c = 0; c < 8; c++) send_cell(8'(c), 8'(c * 3), 8'hE0, 8'(c ^ 8'h5A), 0, 53, c);
      idle(2);
      chk("R7", "ready low when full", 32'(rx_ready), 32'd0);
      d_rv = 1; d_rs = 1; d_rd = 8'h77;
      for (int i = 0; i < 4; i++) cyc();
      d_rv = 0; d_rs = 0;
      chk("R7", "short_count unchanged while full", 32'(short_count), 32'd1);
      for (int k = 0; k < 700; k++) begin
         d_cr = (k % 3) != 0;
         cyc();
      end
      d_cr = 1;
      idle(10);
      chk("R6", "drained", 32'(cell_valid), 32'd0);

      // R9 transmit HEC insertion
      tx_cell(8'h00, 8'h00, 8'h00, 8'h00, 10, 0);
      tx_cell(8'hC3, 8'h19, 8'h7E, 8'h02, 53, 1);
      tx_cell(8'h11, 8'h22, 8'h33, 8'h44, 3, 0);
      tx_cell(8'h99, 8'h88, 8'h77, 8'h66, 12, 1);
      idle(3);

      // R8 saturation with one-byte cells
      for (int i = 0; i < 260; i++) put(8'(i), 1);
      idle(3);
      chk("R8", "short_count saturated", 32'(short_count), 32'(MAXC));
      send_cell(8'h21, 8'h22, 8'h23, 8'h24, 0, 53, 2);
      idle(60);
      chk("R8", "short_count still saturated", 32'(short_count), 32'(MAXC));
      finish_run();
   end
endmodule